// File: doc/BRIEF.md
# TDM Frame Sync Tracker

This block watches the frame-sync strobe of a time-division-multiplexed serial port and decides, for receive and transmit separately, whether the port is locked to the incoming frame structure. Each direction counts bit clocks against a programmable frame length. It climbs through four lock levels before it trusts the framing, and it falls straight back to the bottom level when a strobe arrives at the wrong place or fails to arrive.

The lock level gates the data path. On the receive side, serial bits are assembled into channel words, and a word is presented only if every one of its bits arrived while the receiver was locked. On the transmit side, a supplied channel word is shifted out only while locked. When lock is lost, the transmitter either keeps driving its last bit or drops its output enable, depending on a control input.

A sticky error flag per direction records loss of lock. Software clears a flag by writing 1 to it. Each flag drives an interrupt line through its own enable. Each direction has its own bit-order control.

Top module: `tdm_sync_tracker`

## Requirements
- R1: Each direction reports its lock level on a 2-bit state output coded hunt=0, wait=1, pre-sync=2, locked=3. A sync strobe in hunt moves to wait. A strobe exactly one frame length (in bit ticks) after the previous one moves wait to pre-sync and pre-sync to locked. Both state outputs read hunt after reset.
- R2: In wait or pre-sync, a strobe at any bit other than the expected boundary, or a missing strobe at the boundary, returns the machine to hunt.
- R3: In the locked state, a mis-placed or missing strobe returns the machine to hunt and sets that direction's sticky error flag.
- R4: An interrupt output is high only while its error flag and its enable input are both high.
- R5: A write strobe with err_clr bit 0 (receive) or bit 1 (transmit) set clears the matching flag. A write with that bit at 0 leaves the flag unchanged.
- R6: rx_word_valid pulses for one cycle after the last bit of a channel, and only when all bits of that channel arrived while the receive tracker was locked.
- R7: With rx_lsb_first low, the first received bit of a channel becomes the MSB of rx_word. With it high, the first bit becomes the LSB.
- R8: With tx_lsb_first low, tx_word is sent MSB first. With it high, it is sent LSB first. tx_word is sampled at bit 0 of each channel.
- R9: On a transmit bit tick outside the locked state, no new bit is shifted out. With tx_hold_last high, tx_dout and tx_oe keep their values. With it low, tx_oe goes low.
- R10: Reset clears both error flags, drops tx_oe and rx_word_valid, and sets both trackers to hunt.
- R11: The frame length is programmable in bit ticks (2 up to 2^FRAME_W-1). Lock follows whatever length is programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_frame_len | input | FRAME_W | Receive frame length in bit ticks |
| rx_bit_en | input | 1 | Receive bit tick |
| rx_sync | input | 1 | Receive frame-sync strobe, sampled on a bit tick |
| rx_din | input | 1 | Receive serial data |
| rx_lsb_first | input | 1 | Receive bit order select |
| rx_word_valid | output | 1 | Assembled receive word strobe |
| rx_word | output | WORD_W | Assembled receive word |
| rx_state | output | 2 | Receive lock level |
| tx_frame_len | input | FRAME_W | Transmit frame length in bit ticks |
| tx_bit_en | input | 1 | Transmit bit tick |
| tx_sync | input | 1 | Transmit frame-sync strobe |
| tx_word | input | WORD_W | Channel word to transmit |
| tx_lsb_first | input | 1 | Transmit bit order select |
| tx_hold_last | input | 1 | Keep driving last bit while out of lock |
| tx_word_take | output | 1 | tx_word is consumed this tick |
| tx_dout | output | 1 | Transmit serial data |
| tx_oe | output | 1 | Transmit data output enable |
| tx_state | output | 2 | Transmit lock level |
| err_clr_we | input | 1 | Write strobe for clearing error flags |
| err_clr | input | 2 | Write-1-to-clear bits: 0 receive, 1 transmit |
| rx_err_ie | input | 1 | Receive error interrupt enable |
| tx_err_ie | input | 1 | Transmit error interrupt enable |
| rx_err | output | 1 | Receive sticky sync-loss flag |
| tx_err | output | 1 | Transmit sticky sync-loss flag |
| rx_irq | output | 1 | Receive error interrupt |
| tx_irq | output | 1 | Transmit error interrupt |

## Verification
Several properties are checked on every cycle. The lock level can reach wait only from hunt and locked only from pre-sync. A loss event always lands in hunt and always sets the sticky flag. A flag never drops without a clearing write. A receive word never appears outside the locked state. The transmit output either freezes or releases its enable on an unlocked tick, as tx_hold_last selects. Only the bench scenarios can show that the words carry the right bits in both bit orders, that lock is reached after exactly three correctly spaced strobes with two different frame lengths, and that a missing or mis-placed strobe during acquisition restarts the climb. They also show the per-bit clearing and interrupt masking at the ports.

// File: rtl/tdm_sync_pkg.sv
package tdm_sync_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_WAIT    = 2'd1,
    ST_PRESYNC = 2'd2,
    ST_SYNC    = 2'd3
  } sync_state_e;
endpackage

// File: rtl/tdm_sync_fsm.sv
module tdm_sync_fsm
  import tdm_sync_pkg::*;
#(
  parameter int FRAME_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               sync_in,
  input  logic [FRAME_W-1:0] frame_len,
  output sync_state_e        state,
  output logic               lock_bit,
  output logic               frame_start,
  output logic               loss
);
  localparam logic [FRAME_W-1:0] ONE = FRAME_W'(1);

  sync_state_e        state_n;
  logic [FRAME_W-1:0] pos, pos_n;
  logic               at_edge, good, bad;

  // pos holds the bit index of the last tick relative to the last strobe
  assign at_edge = (pos == (frame_len - ONE));
  assign good    = sync_in && at_edge;
  assign bad     = sync_in ? !at_edge : at_edge;

  always_comb begin
    state_n = state;
    pos_n   = pos;
    loss    = 1'b0;
    if (bit_en) begin
      pos_n = (sync_in || at_edge) ? '0 : pos + ONE;
      unique case (state)
        ST_HUNT:    if (sync_in) state_n = ST_WAIT;
        ST_WAIT:    if (good) state_n = ST_PRESYNC; else if (bad) state_n = ST_HUNT;
        ST_PRESYNC: if (good) state_n = ST_SYNC;    else if (bad) state_n = ST_HUNT;
        ST_SYNC: begin
          if (bad) begin
            state_n = ST_HUNT;
            loss    = 1'b1;
          end
        end
        default:    state_n = ST_HUNT;
      endcase
    end
  end

  assign lock_bit    = bit_en && (state_n == ST_SYNC);
  assign frame_start = lock_bit && good;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HUNT;
      pos   <= '0;
    end else if (bit_en) begin
      state <= state_n;
      pos   <= pos_n;
    end
  end

  AST_WAIT_FROM_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && $past(state) != ST_WAIT) |-> $past(state) == ST_HUNT) // R1
    else $error("wait entered from wrong level");
  AST_SYNC_FROM_PRESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SYNC && $past(state) != ST_SYNC) |-> $past(state) == ST_PRESYNC) // R1
    else $error("lock entered from wrong level");
  AST_LOSS_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    loss |=> state == ST_HUNT) // R3
    else $error("loss did not return to hunt");
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              lock_bit,
  input  logic              frame_start,
  input  logic              din,
  input  logic              lsb_first,
  output logic              word_valid,
  output logic [WORD_W-1:0] word
);
  localparam int CW = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [CW-1:0]     cnt, cnt_n, cur;
  logic [WORD_W-1:0] sh, sh_n, word_n;
  logic              valid_n;

  assign cur = frame_start ? '0 : cnt;

  always_comb begin
    cnt_n   = cnt;
    sh_n    = sh;
    word_n  = word;
    valid_n = 1'b0;
    if (lock_bit) begin
      sh_n = lsb_first ? {din, sh[WORD_W-1:1]} : {sh[WORD_W-2:0], din};
      if (cur == LAST) begin
        cnt_n   = '0;
        valid_n = 1'b1;
        word_n  = sh_n;
      end else begin
        cnt_n = cur + CW'(1);
      end
    end else if (bit_en) begin
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      sh         <= '0;
      word       <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= valid_n;
      if (bit_en) begin
        cnt  <= cnt_n;
        sh   <= sh_n;
        word <= word_n;
      end
    end
  end

  AST_RX_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid || $past(lock_bit)) // R6
    else $error("receive strobe without locked tick");
endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              lock_bit,
  input  logic              frame_start,
  input  logic [WORD_W-1:0] word_in,
  input  logic              lsb_first,
  input  logic              hold_last,
  output logic              word_take,
  output logic              dout,
  output logic              oe
);
  localparam int CW = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [CW-1:0]     cnt, cnt_n, cur, idx;
  logic [WORD_W-1:0] hold, hold_n, src;
  logic              dout_n, oe_n;

  assign cur       = frame_start ? '0 : cnt;
  assign word_take = lock_bit && (cur == '0);
  assign src       = word_take ? word_in : hold;
  assign idx       = lsb_first ? cur : (LAST - cur);

  always_comb begin
    cnt_n  = cnt;
    hold_n = hold;
    dout_n = dout;
    oe_n   = oe;
    if (lock_bit) begin
      dout_n = src[idx];
      oe_n   = 1'b1;
      cnt_n  = (cur == LAST) ? '0 : cur + CW'(1);
      if (word_take) hold_n = word_in;
    end else if (bit_en) begin
      cnt_n = '0;
      if (!hold_last) oe_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      hold <= '0;
      dout <= 1'b0;
      oe   <= 1'b0;
    end else if (bit_en) begin
      cnt  <= cnt_n;
      hold <= hold_n;
      dout <= dout_n;
      oe   <= oe_n;
    end
  end

  AST_TX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !lock_bit && !hold_last) |=> !oe) // R9
    else $error("enable kept while out of lock");
  AST_TX_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !lock_bit && hold_last) |=> ($stable(dout) && $stable(oe))) // R9
    else $error("output moved while out of lock");
endmodule

// File: rtl/tdm_sticky_err.sv
module tdm_sticky_err (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_we,
  input  logic clr_bit,
  input  logic ie,
  output logic flag,
  output logic irq
);
  logic flag_n, clr_hit;

  assign clr_hit = clr_we && clr_bit;

  // a loss event in the same cycle as a clear wins
  always_comb begin
    flag_n = flag;
    if (set_i)        flag_n = 1'b1;
    else if (clr_hit) flag_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_n;
  end

  assign irq = flag && ie;

  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag) // R3
    else $error("loss not recorded");
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_hit) |=> flag) // R5
    else $error("flag dropped without clear");
  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !set_i) |=> !flag) // R5
    else $error("clear write ignored");
endmodule

// File: rtl/tdm_sync_tracker.sv
module tdm_sync_tracker
  import tdm_sync_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int FRAME_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] rx_frame_len,
  input  logic               rx_bit_en,
  input  logic               rx_sync,
  input  logic               rx_din,
  input  logic               rx_lsb_first,
  output logic               rx_word_valid,
  output logic [WORD_W-1:0]  rx_word,
  output logic [1:0]         rx_state,
  input  logic [FRAME_W-1:0] tx_frame_len,
  input  logic               tx_bit_en,
  input  logic               tx_sync,
  input  logic [WORD_W-1:0]  tx_word,
  input  logic               tx_lsb_first,
  input  logic               tx_hold_last,
  output logic               tx_word_take,
  output logic               tx_dout,
  output logic               tx_oe,
  output logic [1:0]         tx_state,
  input  logic               err_clr_we,
  input  logic [1:0]         err_clr,
  input  logic               rx_err_ie,
  input  logic               tx_err_ie,
  output logic               rx_err,
  output logic               tx_err,
  output logic               rx_irq,
  output logic               tx_irq
);
  localparam int NDIR = 2;

  logic [NDIR-1:0]    d_bit_en, d_sync, d_lock, d_fstart, d_loss, d_ie, d_flag, d_irq;
  logic [FRAME_W-1:0] d_len [NDIR];
  sync_state_e        d_state [NDIR];

  assign d_bit_en = {tx_bit_en, rx_bit_en};
  assign d_sync   = {tx_sync, rx_sync};
  assign d_ie     = {tx_err_ie, rx_err_ie};
  assign d_len[0] = rx_frame_len;
  assign d_len[1] = tx_frame_len;

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    tdm_sync_fsm #(.FRAME_W(FRAME_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (d_bit_en[g]),
      .sync_in     (d_sync[g]),
      .frame_len   (d_len[g]),
      .state       (d_state[g]),
      .lock_bit    (d_lock[g]),
      .frame_start (d_fstart[g]),
      .loss        (d_loss[g])
    );
    tdm_sticky_err u_err (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (d_loss[g]),
      .clr_we  (err_clr_we),
      .clr_bit (err_clr[g]),
      .ie      (d_ie[g]),
      .flag    (d_flag[g]),
      .irq     (d_irq[g])
    );
  end

  tdm_rx_deser #(.WORD_W(WORD_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (rx_bit_en),
    .lock_bit    (d_lock[0]),
    .frame_start (d_fstart[0]),
    .din         (rx_din),
    .lsb_first   (rx_lsb_first),
    .word_valid  (rx_word_valid),
    .word        (rx_word)
  );

  tdm_tx_ser #(.WORD_W(WORD_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (tx_bit_en),
    .lock_bit    (d_lock[1]),
    .frame_start (d_fstart[1]),
    .word_in     (tx_word),
    .lsb_first   (tx_lsb_first),
    .hold_last   (tx_hold_last),
    .word_take   (tx_word_take),
    .dout        (tx_dout),
    .oe          (tx_oe)
  );

  assign rx_state = d_state[0];
  assign tx_state = d_state[1];
  assign rx_err   = d_flag[0];
  assign tx_err   = d_flag[1];
  assign rx_irq   = d_irq[0];
  assign tx_irq   = d_irq[1];

  AST_RX_WORD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word_valid |-> rx_state == ST_SYNC) // R6
    else $error("receive word outside lock");
endmodule

// File: tb/tdm_sync_tracker_bench.sv
`timescale 1ns/100ps
module tdm_sync_tracker_bench;
  import tdm_sync_pkg::*;
  localparam int W  = 8;
  localparam int FW = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [FW-1:0] rx_frame_len, tx_frame_len;
  logic rx_bit_en, rx_sync, rx_din, rx_lsb_first, rx_word_valid;
  logic [W-1:0] rx_word, tx_word;
  logic [1:0] rx_state, tx_state, err_clr;
  logic tx_bit_en, tx_sync, tx_lsb_first, tx_hold_last, tx_word_take, tx_dout, tx_oe;
  logic err_clr_we, rx_err_ie, tx_err_ie, rx_err, tx_err, rx_irq, tx_irq;

  always #2.5 clk = ~clk;

  tdm_sync_tracker #(.WORD_W(W), .FRAME_W(FW)) u_tdm_sync_tracker (.*);

  int n_cmp = 0, n_bad = 0, fl = 16, seed = 0;
  bit lsb = 0, hold = 0, exp_oe = 0, exp_dout = 0, done = 0;
  logic [W-1:0] rxq [$];
  logic [2:0]   txq [$];

  task automatic chk(input string req, input int act, input int expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // monitor: sample just after each edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (rx_word_valid) begin
        if (rxq.size() == 0) chk("R6 unexpected word", 1, 0);
        else chk("R7 word", int'(rx_word), int'(rxq.pop_front()));
      end
      if (txq.size() > 0) begin
        logic [2:0] e;
        e = txq.pop_front();
        chk("R9 tx_oe", int'(tx_oe), int'(e[1]));
        if (e[2]) chk("R8 tx_dout", int'(tx_dout), int'(e[0]));
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    rx_bit_en = 0; tx_bit_en = 0; rx_sync = 0; tx_sync = 0; rx_din = 0;
    tx_word = '0; err_clr_we = 0; err_clr = '0;
    exp_oe = 0; exp_dout = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 rx_state", int'(rx_state), 0);
    chk("R10 tx_state", int'(tx_state), 0);
    chk("R10 rx_err", int'(rx_err), 0);
    chk("R10 tx_err", int'(tx_err), 0);
    chk("R10 tx_oe", int'(tx_oe), 0);
    chk("R10 rx_word_valid", int'(rx_word_valid), 0);
  endtask

  // one frame on both directions; locked = frame is in lock from bit 0
  task automatic frame(input bit has_sync, input bit locked, input bit bad5,
                       input sync_state_e exp_st, input string req);
    logic [W-1:0] w = '0;
    rx_frame_len = FW'(fl);
    tx_frame_len = FW'(fl);
    for (int b = 0; b < fl; b++) begin
      int idx;
      bit sy, lk, bv;
      @(negedge clk);
      idx = b % W;
      if (idx == 0) begin
        w = W'(seed * 37 + 11);
        seed++;
      end
      sy = (b == 0 && has_sync) || (b == 5 && bad5);
      lk = locked && !(bad5 && b >= 5);
      bv = lsb ? w[idx] : w[W-1-idx];
      rx_bit_en = 1; tx_bit_en = 1;
      rx_sync = sy; tx_sync = sy; rx_din = bv; tx_word = w;
      if (lk && idx == W-1) rxq.push_back(w);
      if (lk) begin
        exp_oe = 1; exp_dout = bv;
      end else if (!hold) begin
        exp_oe = 0;
      end
      txq.push_back({exp_oe, exp_oe, exp_dout});
    end
    @(negedge clk);
    rx_bit_en = 0; tx_bit_en = 0; rx_sync = 0; tx_sync = 0;
    chk({req, " rx_state"}, int'(rx_state), int'(exp_st));
    chk({req, " tx_state"}, int'(tx_state), int'(exp_st));
  endtask

  task automatic clr_write(input logic [1:0] bits);
    @(negedge clk);
    err_clr_we = 1; err_clr = bits;
    @(negedge clk);
    err_clr_we = 0; err_clr = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rx_frame_len = FW'(16); tx_frame_len = FW'(16);
    rx_lsb_first = 0; tx_lsb_first = 0; tx_hold_last = 0;
    rx_err_ie = 1; tx_err_ie = 1;
    do_reset();

    // first setup: 16-tick frames, MSB first, enable released when out of lock
    fl = 16; lsb = 0; hold = 0;
    frame(1, 0, 0, ST_WAIT,    "R1");
    frame(1, 0, 0, ST_PRESYNC, "R1");
    frame(1, 1, 0, ST_SYNC,    "R1");
    frame(1, 1, 0, ST_SYNC,    "R1");
    frame(1, 1, 1, ST_HUNT,    "R3");
    chk("R3 rx_err", int'(rx_err), 1);
    chk("R3 tx_err", int'(tx_err), 1);
    chk("R4 rx_irq", int'(rx_irq), 1);
    chk("R4 tx_irq", int'(tx_irq), 1);
    frame(1, 0, 0, ST_WAIT,    "R1");
    frame(1, 0, 0, ST_PRESYNC, "R1");
    frame(1, 1, 0, ST_SYNC,    "R1");
    clr_write(2'b00);
    chk("R5 rx_err after zero write", int'(rx_err), 1);
    chk("R5 tx_err after zero write", int'(tx_err), 1);
    clr_write(2'b01);
    chk("R5 rx_err cleared", int'(rx_err), 0);
    chk("R5 tx_err kept", int'(tx_err), 1);
    chk("R4 rx_irq after clear", int'(rx_irq), 0);
    clr_write(2'b10);
    chk("R5 tx_err cleared", int'(tx_err), 0);
    chk("R4 tx_irq after clear", int'(tx_irq), 0);

    // second setup: 24-tick frames, LSB first, hold last bit, receive irq masked
    rx_lsb_first = 1; tx_lsb_first = 1; tx_hold_last = 1;
    rx_err_ie = 0; tx_err_ie = 1;
    fl = 24; lsb = 1; hold = 1;
    do_reset();
    frame(1, 0, 0, ST_WAIT,    "R11");
    frame(0, 0, 0, ST_HUNT,    "R2 missing");
    frame(1, 0, 0, ST_WAIT,    "R11");
    frame(1, 0, 1, ST_HUNT,    "R2 misplaced");
    frame(1, 0, 0, ST_WAIT,    "R11");
    frame(1, 0, 0, ST_PRESYNC, "R11");
    frame(1, 1, 0, ST_SYNC,    "R11");
    chk("R2 no error during acquisition", int'(rx_err), 0);
    frame(1, 1, 1, ST_HUNT,    "R3");
    chk("R3 rx_err", int'(rx_err), 1);
    chk("R4 rx_irq masked", int'(rx_irq), 0);
    chk("R4 tx_irq enabled", int'(tx_irq), 1);
    frame(1, 0, 0, ST_WAIT,    "R11");
    frame(1, 0, 0, ST_PRESYNC, "R11");
    frame(1, 1, 0, ST_SYNC,    "R11");

    repeat (4) @(negedge clk);
    chk("R6 pending words", rxq.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule